// File: doc/BRIEF.md
# Partitioned SIMD Byte-Order Swapper

This block sits in a datapath that carries a 64-bit word split into SIMD elements of 8, 16, 32 or 64 bits. The split can change on every operation. When the endian control asks for a swap, the block reverses the byte order inside each element and leaves element positions unchanged. One copy goes on the operand path, right after the function-unit select multiplexer. A second copy goes on the result path, just before results return to the function units. By default the block is purely combinational, so it adds no pipeline cycle. A parameter can add one output register stage.

The partition is given as a map of break bits, one between each pair of adjacent bytes. Elements must be naturally aligned. Because of that, every output byte comes from one of four fixed sources: the byte itself, its partner in a 2-byte group, its mirror in a 4-byte group, or its mirror in the whole word. A map that describes an element which is not aligned, or whose size is not a power of two, raises an error flag. In that case the word passes through unchanged.

Top module: `bswap_simd`

## Requirements
- R1: Bit i of `brk_i` (i = 0..6) marks an element boundary between byte i and byte i+1, where byte 0 is `data_i[7:0]`. A clear bit joins the two bytes into the same element.
- R2: `err_o` is 1 exactly when some element of the map has a size other than 1, 2, 4 or 8 bytes, or does not start at a multiple of its own size. The value of `swap_i` does not affect `err_o`.
- R3: With `swap_i` = 1 and a valid map, each element of N bytes starting at byte S has output byte S+j equal to input byte S+N-1-j.
- R4: A 1-byte element is never changed, for any value of `swap_i`.
- R5: With `swap_i` = 0, `data_o` equals `data_i` for every map.
- R6: When `err_o` is 1, `data_o` equals `data_i`.
- R7: With `OUT_REG` = 0, the outputs follow the inputs in the same cycle. With `OUT_REG` = 1, they follow one clock later, and they read zero while `rst_n` is low.
- R8: Feeding the output through a second swapper that has the same map and swap control gives back the original word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; used only by the optional output register |
| rst_n | input | 1 | Asynchronous active-low reset of the output register |
| data_i | input | 64 | Word to reorder |
| brk_i | input | 7 | Element boundary map, one bit per adjacent byte pair |
| swap_i | input | 1 | 1 = reverse bytes inside each element, 0 = keep native order |
| data_o | output | 64 | Reordered word, or the input unchanged on error or native mode |
| err_o | output | 1 | Partition map is not naturally aligned |

## Verification
The bench builds three instances with the default 8-byte width. Two are combinational (`OUT_REG` = 0) and are chained back to back. This lets a zero-latency result and the double-swap round trip be checked in the same cycle. The third instance uses `OUT_REG` = 1. It brings the one-cycle delay and the zeroed reset value within reach of the checks. Random naturally aligned partitions come from an independent model that reverses elements. Directed maps cover misaligned, odd-sized and native-mode cases.

// File: rtl/bswap_pkg.sv
package bswap_pkg;
    localparam int unsigned BYTE_W = 8;

    // number of selectable group levels for a word of nbytes (sizes 1,2,..,nbytes)
    function automatic int unsigned level_count(input int unsigned nbytes);
        return $clog2(nbytes) + 1;
    endfunction
endpackage

// File: rtl/bswap_span_decode.sv
// Turns the boundary map into a per-byte group level and an alignment error.
module bswap_span_decode #(
    parameter int unsigned NB = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NB-2:0]             brk_i,
    output logic [NB-1:0][$clog2($clog2(NB)+1)-1:0] lvl_o,
    output logic                      err_o
);
    localparam int unsigned LOG = $clog2(NB);
    localparam int unsigned LW  = $clog2(LOG + 1);

    logic [NB-1:0][LOG:0] clean;    // aligned group at level k has no inner break
    logic [NB-1:0][LOG:0] edge_ok;  // both outer edges of that group are boundaries
    logic [NB-1:0]        byte_err;

    for (genvar b = 0; b < NB; b++) begin : g_byte
        for (genvar k = 0; k <= LOG; k++) begin : g_lvl
            localparam int unsigned SZ = 1 << k;
            localparam int unsigned S  = (b >> k) << k;
            logic lft, rgt;
            if (k == 0) begin : g_single
                assign clean[b][k] = 1'b1;
            end else begin : g_multi
                assign clean[b][k] = ~|brk_i[S+SZ-2:S];
            end
            if (S == 0) begin : g_lft_word
                assign lft = 1'b1;
            end else begin : g_lft_brk
                assign lft = brk_i[S-1];
            end
            if (S + SZ == NB) begin : g_rgt_word
                assign rgt = 1'b1;
            end else begin : g_rgt_brk
                assign rgt = brk_i[S+SZ-1];
            end
            assign edge_ok[b][k] = lft & rgt;
        end
    end

    always_comb begin
        for (int b = 0; b < NB; b++) begin
            lvl_o[b] = '0;
            for (int k = 1; k <= LOG; k++) begin
                if (clean[b][k]) lvl_o[b] = LW'(k);
            end
            byte_err[b] = ~edge_ok[b][lvl_o[b]];
        end
    end

    assign err_o = |byte_err;

    // R2
    full_split_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (&brk_i) |-> !err_o);
    // R2
    whole_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (brk_i == '0) |-> (!err_o && lvl_o[0] == LW'(LOG)));
endmodule

// File: rtl/bswap_byte_mux.sv
// Selects, for every byte, one of the fixed mirror permutations.
module bswap_byte_mux #(
    parameter int unsigned NB = 8
) (
    input  logic                                   clk,
    input  logic                                   rst_n,
    input  logic [NB*bswap_pkg::BYTE_W-1:0]         data_i,
    input  logic [NB-1:0][$clog2($clog2(NB)+1)-1:0] lvl_i,
    input  logic                                   en_i,
    output logic [NB*bswap_pkg::BYTE_W-1:0]         data_o
);
    import bswap_pkg::*;
    localparam int unsigned LOG = $clog2(NB);
    localparam int unsigned LW  = $clog2(LOG + 1);

    logic [NB-1:0][BYTE_W-1:0]        in_b, out_b;
    logic [NB-1:0][LOG:0][BYTE_W-1:0] cand;

    assign in_b = data_i;

    for (genvar b = 0; b < NB; b++) begin : g_byte
        for (genvar k = 0; k <= LOG; k++) begin : g_perm
            localparam int unsigned SRC = b ^ ((1 << k) - 1);
            assign cand[b][k] = in_b[SRC];
        end

        // R4
        single_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (lvl_i[b] == '0) |-> (out_b[b] == in_b[b]));
    end

    always_comb begin
        for (int b = 0; b < NB; b++) begin
            out_b[b] = in_b[b];
            if (en_i) begin
                for (int k = 0; k <= LOG; k++) begin
                    if (lvl_i[b] == LW'(k)) out_b[b] = cand[b][k];
                end
            end
        end
    end

    assign data_o = out_b;
endmodule

// File: rtl/bswap_simd.sv
module bswap_simd #(
    parameter int unsigned NUM_BYTES = 8,
    parameter bit          OUT_REG   = 1'b0
) (
    input  logic                                    clk,
    input  logic                                    rst_n,
    input  logic [NUM_BYTES*bswap_pkg::BYTE_W-1:0]  data_i,
    input  logic [NUM_BYTES-2:0]                    brk_i,
    input  logic                                    swap_i,
    output logic [NUM_BYTES*bswap_pkg::BYTE_W-1:0]  data_o,
    output logic                                    err_o
);
    import bswap_pkg::*;
    localparam int unsigned DATA_W = NUM_BYTES * BYTE_W;
    localparam int unsigned LOG    = $clog2(NUM_BYTES);
    localparam int unsigned LW     = $clog2(LOG + 1);

    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic              err;
    } out_t;

    out_t st_d, st_q;

    logic [NUM_BYTES-1:0][LW-1:0] lvl;
    logic                         map_err;
    logic [DATA_W-1:0]            swapped;

    bswap_span_decode #(.NB(NUM_BYTES)) u_decode (
        .clk   (clk),
        .rst_n (rst_n),
        .brk_i (brk_i),
        .lvl_o (lvl),
        .err_o (map_err)
    );

    bswap_byte_mux #(.NB(NUM_BYTES)) u_mux (
        .clk    (clk),
        .rst_n  (rst_n),
        .data_i (data_i),
        .lvl_i  (lvl),
        .en_i   (swap_i & ~map_err),
        .data_o (swapped)
    );

    always_comb begin
        st_d      = '0;
        st_d.data = swapped;
        st_d.err  = map_err;
    end

    if (OUT_REG) begin : g_reg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) st_q <= '0;
            else        st_q <= st_d;
        end

        // R7
        reg_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $past(rst_n) |-> (st_q == $past(st_d)));
    end else begin : g_comb
        assign st_q = st_d;
    end

    assign data_o = st_q.data;
    assign err_o  = st_q.err;

    // R5
    native_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !swap_i |-> (st_d.data == data_i));
    // R6
    err_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_d.err |-> (st_d.data == data_i));
    // R3
    byte_mass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (swap_i && !st_d.err) |-> ($countones(st_d.data) == $countones(data_i)));
endmodule

// File: tb/tb_bswap_simd.sv
module tb_bswap_simd;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] data_i = '0;
    logic [6:0]  brk_i = '0;
    logic        swap_i = 1'b0;
    logic [63:0] data_c, data_2, data_r;
    logic        err_c, err_2, err_r;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    bswap_simd #(.NUM_BYTES(8), .OUT_REG(1'b0)) dut (
        .clk(clk), .rst_n(rst_n), .data_i(data_i), .brk_i(brk_i),
        .swap_i(swap_i), .data_o(data_c), .err_o(err_c));

    bswap_simd #(.NUM_BYTES(8), .OUT_REG(1'b0)) dut_twice (
        .clk(clk), .rst_n(rst_n), .data_i(data_c), .brk_i(brk_i),
        .swap_i(swap_i), .data_o(data_2), .err_o(err_2));

    bswap_simd #(.NUM_BYTES(8), .OUT_REG(1'b1)) dut_reg (
        .clk(clk), .rst_n(rst_n), .data_i(data_i), .brk_i(brk_i),
        .swap_i(swap_i), .data_o(data_r), .err_o(err_r));

    // {data_in, brk, swap, expected_data, expected_err}
    localparam int NV = 10;
    localparam logic [136:0] VEC [NV] = '{
        {64'h8877665544332211, 7'h7F, 1'b1, 64'h8877665544332211, 1'b0}, // R4 all bytes
        {64'h8877665544332211, 7'h00, 1'b1, 64'h1122334455667788, 1'b0}, // R3 whole word
        {64'h8877665544332211, 7'h2A, 1'b1, 64'h7788556633441122, 1'b0}, // R3 pairs
        {64'h8877665544332211, 7'h08, 1'b1, 64'h5566778811223344, 1'b0}, // R3 quads
        {64'h8877665544332211, 7'h0B, 1'b1, 64'h5566778833442211, 1'b0}, // R1 mixed
        {64'h8877665544332211, 7'h63, 1'b1, 64'h8877665544332211, 1'b1}, // R6 quad at byte 2
        {64'h8877665544332211, 7'h2A, 1'b0, 64'h8877665544332211, 1'b0}, // R5 native
        {64'h0F1E2D3C4B5A6978, 7'h7D, 1'b1, 64'h0F1E2D3C4B5A6978, 1'b1}, // R6 pair at byte 1
        {64'h0F1E2D3C4B5A6978, 7'h7C, 1'b1, 64'h0F1E2D3C4B5A6978, 1'b1}, // R2 three-byte
        {64'h0F1E2D3C4B5A6978, 7'h63, 1'b0, 64'h0F1E2D3C4B5A6978, 1'b1}  // R2 err in native
    };

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL R7 watchdog actual=expired expected=finished");
        finish_run();
    end

    initial begin : stim
        logic [63:0] d, e;
        logic [6:0]  m;
        // reset state of the registered copy (R7)
        data_i = 64'hDEADBEEFCAFEF00D;
        brk_i  = 7'h63;
        swap_i = 1'b1;
        repeat (3) @(negedge clk);
        chk("R7 reset data", data_r, 64'h0);
        chk("R7 reset err", {63'h0, err_r}, 64'h0);
        rst_n = 1'b1;

        for (int v = 0; v < NV; v++) begin
            @(negedge clk);
            {data_i, brk_i, swap_i, e, d[0]} = VEC[v];
            #2;
            chk($sformatf("R3 R7 table %0d data", v), data_c, e);
            chk($sformatf("R2 table %0d err", v), {63'h0, err_c}, {63'h0, d[0]});
            chk($sformatf("R8 table %0d round trip", v), data_2, data_i);
            @(posedge clk);
            #2;
            chk($sformatf("R7 table %0d registered", v), data_r, e);
            chk($sformatf("R7 table %0d registered err", v), {63'h0, err_r}, {63'h0, d[0]});
        end

        // random aligned partitions against an element-reversal model
        for (int t = 0; t < 300; t++) begin
            int pos;
            logic sw;
            @(negedge clk);
            d   = {$urandom, $urandom};
            sw  = 1'($urandom);
            m   = '0;
            e   = d;
            pos = 0;
            while (pos < 8) begin
                int sz;
                do sz = 1 << ($urandom % 4); while ((pos % sz) != 0 || pos + sz > 8);
                if (pos + sz - 1 < 7) m[pos+sz-1] = 1'b1;
                if (sw) begin
                    for (int j = 0; j < sz; j++)
                        e[8*(pos+j) +: 8] = d[8*(pos+sz-1-j) +: 8];
                end
                pos += sz;
            end
            data_i = d;
            brk_i  = m;
            swap_i = sw;
            #2;
            chk($sformatf("R3 R5 random %0d", t), data_c, e);
            chk($sformatf("R2 random %0d err", t), {63'h0, err_c}, 64'h0);
            chk($sformatf("R8 random %0d round trip", t), data_2, d);
        end

        // native mode over every map (R5) and error independence from mode (R2)
        for (int mm = 0; mm < 128; mm++) begin
            @(negedge clk);
            data_i = 64'h0123456789ABCDEF;
            brk_i  = 7'(mm);
            swap_i = 1'b0;
            #2;
            chk($sformatf("R5 native map %0d", mm), data_c, 64'h0123456789ABCDEF);
            d[0] = err_c;
            swap_i = 1'b1;
            #2;
            chk($sformatf("R2 map %0d err vs mode", mm), {63'h0, err_c}, {63'h0, d[0]});
            if (err_c) chk($sformatf("R6 map %0d pass", mm), data_c, 64'h0123456789ABCDEF);
        end

        finish_run();
    end
endmodule